// File: doc/BRIEF.md
# Filtered Performance Event Counter Bank

This block is a small bank of programmable event counters for a processor pipeline. In every cycle the pipeline presents a set of event pulses: instructions retired (as a count, to allow dual issue), a store retired, a load or store that passed through its alignment check, an exception entry, and an exception return. With these pulses it gives the privilege level and security state in which the event was executed. Each counter picks one event, has an enable bit, and has one exclusion mask per security state. It adds the event's weight only when the originating context is not excluded.

The counting rules follow the architectural meaning of each event. A store-exclusive that fails is not a retired store. An access that passes its alignment check is never an unaligned event, even when it is a paired-word access that is only word aligned. Exception entry and exception return are always judged in the context they were executed in, never in the context they go to. Software uses a flat register window to read, preset or clear the counters, to set each counter's configuration, and to read and clear the sticky wrap flags.

Top module: `perf_counter_bank`

## Requirements
- R1: After a synchronous reset, every counter, every configuration word and every wrap flag reads as zero.
- R2: With event code 0 selected, a counter adds the 2-bit retire count (0 to 3) given in that cycle.
- R3: With event code 1 selected, a counter adds one for each retired store, and adds nothing when the failed-exclusive flag accompanies the store.
- R4: With event code 2 selected, a counter adds one only for an access whose alignment check faulted. An access that passes its check is never counted, and this includes a paired-word access that is only word aligned.
- R5: Event codes 3 (exception entry) and 4 (exception return) are filtered by the level and security state in which the exception or return was executed. An event from an allowed origin counts even when its destination context is excluded, and an event from an excluded origin never counts.
- R6: Each counter has two 4-bit exclusion masks, one for secure and one for non-secure state, indexed by privilege level 0 to 3. A set bit suppresses counting for that level and state. Counters filter independently of one another.
- R7: A counter whose enable bit is clear never changes except through a software write, and event codes 5 to 7 never count.
- R8: Register window (4-bit address). Addresses 0 to 3 hold counter values. Addresses 4 to 7 hold the configuration of counters 0 to 3: bit 0 is the enable, bits 3:1 the event code, bits 7:4 the secure exclusion mask, bits 11:8 the non-secure exclusion mask. Address 8 holds the wrap flags, with bit i belonging to counter i. Reads are combinational, a write lands at the next clock edge, and addresses 9 to 15 read as zero.
- R9: When an increment carries a counter past all ones, the counter keeps the wrapped sum and its wrap flag is set. The flag stays set until software writes a one to that bit at address 8. A wrap in the same cycle as that clear leaves the flag set.
- R10: A software write to a counter in the same cycle as a countable event stores the written value, drops the event, and does not set the wrap flag.
- R11: A configuration write applies to events from the following cycle on. An event in the cycle of the write is judged with the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_inst_cnt | input | 2 | Instructions retired this cycle |
| ev_store | input | 1 | A store retired this cycle |
| ev_store_xfail | input | 1 | The retired store was an exclusive that failed |
| ev_ldst | input | 1 | A load or store went through its alignment check |
| ev_ldst_fault | input | 1 | That access failed its alignment check |
| ev_exc_take | input | 1 | An exception was taken this cycle |
| ev_exc_ret | input | 1 | An exception return executed this cycle |
| ev_lvl | input | 2 | Privilege level in which this cycle's events executed |
| ev_ns | input | 1 | Security state of this cycle's events (1 = non-secure) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |

## Verification
The counters and flags have a single register stage. An event or a write presented during one cycle is visible at the read port just after the next rising edge, and a configuration write affects events starting one cycle after that write. Each bench task drives its stimulus 1 ns after a rising edge and holds it for exactly one edge. It then reads the window 1 ns after that edge and compares the result with a count built from the requirement rules. Same-cycle conflicts (write against event, wrap against clear, configuration change against event) are driven in a single cycle so that the priority rule decides the result that is read.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int LVL_N  = 4;
    localparam int LVL_W  = $clog2(LVL_N);
    localparam int SEL_W  = 3;
    localparam int STEP_W = 2;

    typedef enum logic [SEL_W-1:0] {
        EV_INST     = 3'd0,
        EV_STORE    = 3'd1,
        EV_UNALIGN  = 3'd2,
        EV_EXC_TAKE = 3'd3,
        EV_EXC_RET  = 3'd4
    } ev_code_e;

    // packed: en in bit 0, sel above it, then secure mask, then non-secure mask
    typedef struct packed {
        logic [LVL_N-1:0] ns_excl;
        logic [LVL_N-1:0] s_excl;
        logic [SEL_W-1:0] sel;
        logic             en;
    } ctr_cfg_t;
endpackage

// File: rtl/pmc_event_mux.sv
module pmc_event_mux
    import pmc_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [STEP_W-1:0] inst_cnt,
    input  logic              st_ret,
    input  logic              st_xfail,
    input  logic              ldst_vld,
    input  logic              ldst_fault,
    input  logic              exc_take,
    input  logic              exc_ret,
    output logic [STEP_W-1:0] amt
);
    always_comb begin
        amt = '0;
        case (sel)
            EV_INST:     amt = inst_cnt;
            EV_STORE:    amt = STEP_W'(st_ret && !st_xfail);
            EV_UNALIGN:  amt = STEP_W'(ldst_vld && ldst_fault);
            EV_EXC_TAKE: amt = STEP_W'(exc_take);
            EV_EXC_RET:  amt = STEP_W'(exc_ret);
            default:     amt = '0;
        endcase
    end
endmodule

// File: rtl/pmc_ctx_filter.sv
module pmc_ctx_filter
    import pmc_pkg::*;
(
    input  logic [LVL_N-1:0] s_excl,
    input  logic [LVL_N-1:0] ns_excl,
    input  logic [LVL_W-1:0] lvl,
    input  logic             ns,
    output logic             allow
);
    logic [LVL_N-1:0] excl;

    assign excl  = ns ? ns_excl : s_excl;
    assign allow = !excl[lvl];
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
    import pmc_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [STEP_W-1:0]                  ev_inst_cnt,
    input  logic                               ev_store,
    input  logic                               ev_store_xfail,
    input  logic                               ev_ldst,
    input  logic                               ev_ldst_fault,
    input  logic                               ev_exc_take,
    input  logic                               ev_exc_ret,
    input  logic [LVL_W-1:0]                   ev_lvl,
    input  logic                               ev_ns,
    input  logic                               reg_we,
    input  logic [$clog2(2*NUM_CNT+1)-1:0]     reg_addr,
    input  logic [CNT_W-1:0]                   reg_wdata,
    output logic [CNT_W-1:0]                   reg_rdata
);
    localparam int CFG_W  = $bits(ctr_cfg_t);
    localparam int ADDR_W = $clog2(2*NUM_CNT+1);
    localparam logic [ADDR_W-1:0] OVF_ADDR = ADDR_W'(2*NUM_CNT);

    typedef struct packed {
        logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
        ctr_cfg_t [NUM_CNT-1:0]        cfg;
        logic [NUM_CNT-1:0]            ovf;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_view;
    logic [NUM_CNT-1:0]             en_view;
    logic [NUM_CNT-1:0]             ovf_view;
    logic [NUM_CNT-1:0][STEP_W-1:0] step;
    logic [NUM_CNT-1:0][CNT_W:0]    sum;
    logic [NUM_CNT-1:0]             wr_cnt;
    logic [NUM_CNT-1:0]             wr_cfg;
    logic                           wr_ovf;

    assign wr_ovf   = reg_we && (reg_addr == OVF_ADDR);
    assign ovf_view = st_q.ovf;

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_ctr
        logic [STEP_W-1:0] amt;
        logic              allow;

        pmc_event_mux u_mux (
            .sel        (st_q.cfg[g].sel),
            .inst_cnt   (ev_inst_cnt),
            .st_ret     (ev_store),
            .st_xfail   (ev_store_xfail),
            .ldst_vld   (ev_ldst),
            .ldst_fault (ev_ldst_fault),
            .exc_take   (ev_exc_take),
            .exc_ret    (ev_exc_ret),
            .amt        (amt)
        );

        pmc_ctx_filter u_flt (
            .s_excl  (st_q.cfg[g].s_excl),
            .ns_excl (st_q.cfg[g].ns_excl),
            .lvl     (ev_lvl),
            .ns      (ev_ns),
            .allow   (allow)
        );

        assign cnt_view[g] = st_q.cnt[g];
        assign en_view[g]  = st_q.cfg[g].en;
        assign step[g]     = (en_view[g] && allow) ? amt : '0;
        assign sum[g]      = {1'b0, cnt_view[g]} + (CNT_W+1)'(step[g]);
        assign wr_cnt[g]   = reg_we && (reg_addr == ADDR_W'(g));
        assign wr_cfg[g]   = reg_we && (reg_addr == ADDR_W'(NUM_CNT + g));
    end

    always_comb begin
        logic [NUM_CNT-1:0] wrap;
        st_d = st_q;
        wrap = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (wr_cnt[i]) begin
                st_d.cnt[i] = reg_wdata;
            end else begin
                st_d.cnt[i] = sum[i][CNT_W-1:0];
                wrap[i]     = sum[i][CNT_W];
            end
            if (wr_cfg[i]) begin
                st_d.cfg[i] = ctr_cfg_t'(reg_wdata[CFG_W-1:0]);
            end
        end
        if (wr_ovf) begin
            st_d.ovf = st_q.ovf & ~reg_wdata[NUM_CNT-1:0];
        end
        st_d.ovf = st_d.ovf | wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (reg_addr == ADDR_W'(i)) begin
                reg_rdata = cnt_view[i];
            end
            if (reg_addr == ADDR_W'(NUM_CNT + i)) begin
                reg_rdata = {{(CNT_W-CFG_W){1'b0}}, st_q.cfg[i]};
            end
        end
        if (reg_addr == OVF_ADDR) begin
            reg_rdata = {{(CNT_W-NUM_CNT){1'b0}}, ovf_view};
        end
    end
endmodule

// File: rtl/pmc_bank_checker.sv
module pmc_bank_checker #(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32
) (
    input logic                               clk,
    input logic                               rst,
    input logic                               reg_we,
    input logic [$clog2(2*NUM_CNT+1)-1:0]     reg_addr,
    input logic [CNT_W-1:0]                   reg_wdata,
    input logic [NUM_CNT-1:0][CNT_W-1:0]      cnt,
    input logic [NUM_CNT-1:0]                 en,
    input logic [NUM_CNT-1:0]                 ovf
);
    localparam int ADDR_W = $clog2(2*NUM_CNT+1);
    localparam logic [ADDR_W-1:0] OVF_ADDR = ADDR_W'(2*NUM_CNT);

    p_rst_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt == '0 && en == '0 && ovf == '0));

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        p_wr_wins_r10: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && $past(reg_we) && $past(reg_addr) == ADDR_W'(i))
            |-> cnt[i] == $past(reg_wdata));

        p_hold_disabled_r7: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && !$past(en[i]) &&
             !($past(reg_we) && $past(reg_addr) == ADDR_W'(i)))
            |-> $stable(cnt[i]));

        p_step_max_r2: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && !($past(reg_we) && $past(reg_addr) == ADDR_W'(i)))
            |-> CNT_W'(cnt[i] - $past(cnt[i])) <= CNT_W'(3));

        p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && $past(ovf[i]) &&
             !($past(reg_we) && $past(reg_addr) == OVF_ADDR && $past(reg_wdata[i])))
            |-> ovf[i]);
    end
endmodule

bind perf_counter_bank pmc_bank_checker #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cnt       (cnt_view),
    .en        (en_view),
    .ovf       (ovf_view)
);

// File: tb/perf_counter_bank_bench.sv
`timescale 1ns/1ps
module perf_counter_bank_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  ev_inst_cnt;
    logic        ev_store, ev_store_xfail, ev_ldst, ev_ldst_fault;
    logic        ev_exc_take, ev_exc_ret;
    logic [1:0]  ev_lvl;
    logic        ev_ns;
    logic        reg_we;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    perf_counter_bank u_perf_counter_bank (
        .clk(clk), .rst(rst), .ev_inst_cnt(ev_inst_cnt), .ev_store(ev_store),
        .ev_store_xfail(ev_store_xfail), .ev_ldst(ev_ldst), .ev_ldst_fault(ev_ldst_fault),
        .ev_exc_take(ev_exc_take), .ev_exc_ret(ev_exc_ret), .ev_lvl(ev_lvl), .ev_ns(ev_ns),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [31:0] mkcfg(input logic en, input logic [2:0] sel,
                                          input logic [3:0] s_x, input logic [3:0] ns_x);
        return {20'b0, ns_x, s_x, sel, en};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_ev();
        ev_inst_cnt = '0; ev_store = 0; ev_store_xfail = 0; ev_ldst = 0;
        ev_ldst_fault = 0; ev_exc_take = 0; ev_exc_ret = 0; ev_lvl = '0; ev_ns = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rdchk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    // one cycle of events, then idle
    task automatic fire(input logic [1:0] inst, input logic st, input logic xf,
                        input logic ld, input logic flt, input logic tk, input logic rt,
                        input logic [1:0] lvl, input logic ns);
        ev_inst_cnt = inst; ev_store = st; ev_store_xfail = xf; ev_ldst = ld;
        ev_ldst_fault = flt; ev_exc_take = tk; ev_exc_ret = rt; ev_lvl = lvl; ev_ns = ns;
        tick();
        idle_ev();
    endtask

    task automatic t_reset();
        for (int a = 0; a < 16; a++) rdchk("R1/R8 reset read", 4'(a), 32'h0);
    endtask

    task automatic t_inst();
        wr(4'd0, 0);
        wr(4'd4, mkcfg(1, 3'd0, 4'h0, 4'h0));
        wr(4'd1, 0);
        wr(4'd5, mkcfg(1, 3'd5, 4'h0, 4'h0));
        fire(2'd1, 0,0,0,0,0,0, 2'd0, 0);
        fire(2'd2, 0,0,0,0,0,0, 2'd0, 0);
        fire(2'd3, 0,0,0,0,0,0, 2'd0, 0);
        fire(2'd0, 0,0,0,0,0,0, 2'd0, 0);
        fire(2'd3, 1,0,1,1,1,1, 2'd0, 0);
        rdchk("R2 retire count sum", 4'd0, 32'd9);
        rdchk("R7 unused event code", 4'd1, 32'd0);
        rdchk("R8 config readback", 4'd5, mkcfg(1, 3'd5, 4'h0, 4'h0));
    endtask

    task automatic t_store();
        wr(4'd1, 0);
        wr(4'd5, mkcfg(1, 3'd1, 4'h0, 4'h0));
        for (int k = 0; k < 3; k++) fire(2'd3, 1,0,0,0,0,0, 2'd0, 0);
        fire(2'd0, 1,1,0,0,0,0, 2'd0, 0);
        fire(2'd0, 1,1,0,0,0,0, 2'd0, 0);
        fire(2'd0, 0,1,0,0,0,0, 2'd0, 0);
        rdchk("R3 failed exclusive excluded", 4'd1, 32'd3);
    endtask

    task automatic t_unalign();
        wr(4'd2, 0);
        wr(4'd6, mkcfg(1, 3'd2, 4'h0, 4'h0));
        fire(2'd0, 0,0,1,1,0,0, 2'd0, 0);
        for (int k = 0; k < 3; k++) fire(2'd0, 0,0,1,0,0,0, 2'd0, 0);
        fire(2'd0, 0,0,1,1,0,0, 2'd2, 1);
        fire(2'd0, 0,0,0,1,0,0, 2'd0, 0);
        rdchk("R4 only faulting accesses", 4'd2, 32'd2);
    endtask

    task automatic t_exc();
        wr(4'd3, 0);
        // secure level 1 excluded: entry from secure 0 into secure 1 still counts
        wr(4'd7, mkcfg(1, 3'd3, 4'b0010, 4'h0));
        fire(2'd0, 0,0,0,0,1,0, 2'd0, 0);
        rdchk("R5 entry from allowed origin", 4'd3, 32'd1);
        fire(2'd0, 0,0,0,0,1,0, 2'd1, 0);
        rdchk("R5 entry from excluded origin", 4'd3, 32'd1);
        fire(2'd0, 0,0,0,0,1,0, 2'd1, 1);
        fire(2'd0, 0,0,0,0,0,1, 2'd0, 0);
        rdchk("R5 entry count, return ignored", 4'd3, 32'd2);
        wr(4'd7, mkcfg(1, 3'd4, 4'b0010, 4'h0));
        wr(4'd3, 0);
        fire(2'd0, 0,0,0,0,0,1, 2'd1, 0);
        rdchk("R5 return from excluded origin", 4'd3, 32'd0);
        fire(2'd0, 0,0,0,0,0,1, 2'd3, 1);
        fire(2'd0, 0,0,0,0,1,0, 2'd3, 1);
        rdchk("R5 return from allowed origin", 4'd3, 32'd1);
    endtask

    task automatic t_filter();
        logic [3:0] s_x  = 4'b0101;
        logic [3:0] ns_x = 4'b1010;
        int exp0 = 0;
        wr(4'd0, 0);
        wr(4'd1, 0);
        wr(4'd4, mkcfg(1, 3'd0, s_x, ns_x));
        wr(4'd5, mkcfg(1, 3'd0, 4'h0, 4'h0));
        for (int ns = 0; ns < 2; ns++) begin
            for (int l = 0; l < 4; l++) begin
                fire(2'd1, 0,0,0,0,0,0, 2'(l), 1'(ns));
                if (!((ns != 0) ? ns_x[l] : s_x[l])) exp0++;
                rdchk("R6 mask per level and state", 4'd0, 32'(exp0));
            end
        end
        rdchk("R6 unfiltered neighbour", 4'd1, 32'd8);
    endtask

    task automatic t_disable();
        wr(4'd0, 32'd77);
        wr(4'd4, mkcfg(0, 3'd0, 4'h0, 4'h0));
        fire(2'd3, 0,0,0,0,0,0, 2'd0, 0);
        fire(2'd2, 0,0,0,0,0,0, 2'd3, 1);
        rdchk("R7 disabled holds", 4'd0, 32'd77);
    endtask

    task automatic t_overflow();
        wr(4'd8, 32'hF);
        wr(4'd4, mkcfg(1, 3'd0, 4'h0, 4'h0));
        wr(4'd0, 32'hFFFF_FFFE);
        fire(2'd3, 0,0,0,0,0,0, 2'd0, 0);
        rdchk("R9 wrapped sum", 4'd0, 32'd1);
        rdchk("R9 flag set", 4'd8, 32'h1);
        fire(2'd1, 0,0,0,0,0,0, 2'd0, 0);
        rdchk("R9 flag sticky", 4'd8, 32'h1);
        wr(4'd8, 32'h2);
        rdchk("R9 clear other bit", 4'd8, 32'h1);
        wr(4'd8, 32'h1);
        rdchk("R9 clear own bit", 4'd8, 32'h0);
        wr(4'd0, 32'hFFFF_FFFF);
        reg_we = 1; reg_addr = 4'd8; reg_wdata = 32'h1; ev_inst_cnt = 2'd1;
        tick();
        reg_we = 0; idle_ev();
        rdchk("R9 wrap beats clear", 4'd8, 32'h1);
        rdchk("R9 wrap to zero", 4'd0, 32'd0);
    endtask

    task automatic t_wr_wins();
        wr(4'd8, 32'hF);
        wr(4'd4, mkcfg(1, 3'd0, 4'h0, 4'h0));
        wr(4'd0, 32'hFFFF_FFFF);
        reg_we = 1; reg_addr = 4'd0; reg_wdata = 32'd5; ev_inst_cnt = 2'd3;
        tick();
        reg_we = 0; idle_ev();
        rdchk("R10 written value kept", 4'd0, 32'd5);
        rdchk("R10 no wrap flag", 4'd8, 32'h0);
        reg_we = 1; reg_addr = 4'd0; reg_wdata = 32'd100; ev_inst_cnt = 2'd2;
        tick();
        reg_we = 0; idle_ev();
        rdchk("R10 event dropped", 4'd0, 32'd100);
    endtask

    task automatic t_cfg_timing();
        wr(4'd5, mkcfg(0, 3'd1, 4'h0, 4'h0));
        wr(4'd1, 0);
        reg_we = 1; reg_addr = 4'd5; reg_wdata = mkcfg(1, 3'd1, 4'h0, 4'h0); ev_store = 1;
        tick();
        reg_we = 0; idle_ev();
        rdchk("R11 old config in write cycle", 4'd1, 32'd0);
        fire(2'd0, 1,0,0,0,0,0, 2'd0, 0);
        rdchk("R11 new config next cycle", 4'd1, 32'd1);
        wr(4'd12, 32'hFFFF_FFFF);
        rdchk("R8 unmapped reads zero", 4'd12, 32'd0);
        rdchk("R8 unmapped write no effect", 4'd1, 32'd1);
    endtask

    initial begin
        rst = 1; reg_we = 0; reg_addr = '0; reg_wdata = '0;
        idle_ev();
        repeat (3) tick();
        rst = 0;
        t_reset();
        t_inst();
        t_store();
        t_unalign();
        t_exc();
        t_filter();
        t_disable();
        t_overflow();
        t_wr_wins();
        t_cfg_timing();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule